// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block stores a four-bit decimal digit code and converts it into the seven active-high segment drives of a numeric display. While the hold control is low, the stored code is refreshed from the input on every rising clock edge. While it is high, the last loaded code stays in place, so a shared data bus can serve many digits in turn. Codes above nine are shown as a dark digit.

Two override inputs act on the segments. A lamp-test input turns every segment on and beats everything else. A blanking input turns every segment off, which can also be used for brightness pulsing. A ripple-blanking input and output let a row of these blocks drop redundant zeros. A digit whose stored code is zero goes dark when its ripple input is high. Its ripple output is high only when its ripple input is high and its stored code is zero. Chaining the ripple signals from the most significant digit downward removes leading zeros. Chaining them from the last fractional digit upward removes trailing zeros.

Top module: `bcd_seg_latch_dec`

## Requirements
- R1: When hold_i is low at a rising clock edge, the stored code takes the value of bcd_i, and the segments reflect it after that edge.
- R2: When hold_i is high at a rising clock edge, the stored code keeps its value, whatever bcd_i does.
- R3: An active-low asynchronous reset (rst_ni) clears the stored code to 0.
- R4: When lamp_test_ni is low, seg_o is 7'b1111111, regardless of blanking, ripple input or code.
- R5: When blank_ni is low and lamp_test_ni is high, seg_o is 7'b0000000.
- R6: Stored codes 10 to 15 give seg_o = 7'b0000000 when no override is active.
- R7: Stored codes 0 to 9 with no override and no ripple blanking show these patterns, with bit 6 = segment a down to bit 0 = segment g: 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B (hex).
- R8: A stored code of 0 with rip_in_i high and no override gives seg_o = 7'b0000000.
- R9: rip_out_o is high exactly when rip_in_i is high and the stored code is 0, and lamp test and blanking have no effect on it.
- R10: Four instances chained through their ripple signals blank leading zeros, with the most significant digit's ripple input high and the units digit's ripple input low. Chained the other way, with the last fractional digit's ripple input high and the digit next to the point tied low, they blank trailing zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bcd_i | input | 4 | Digit code input |
| hold_i | input | 1 | High keeps the stored code; low loads bcd_i at each edge |
| lamp_test_ni | input | 1 | Active-low lamp test, all segments on |
| blank_ni | input | 1 | Active-low blanking, all segments off |
| rip_in_i | input | 1 | Ripple-blanking input |
| seg_o | output | 7 | Segments a (bit 6) to g (bit 0), active high |
| rip_out_o | output | 1 | Ripple-blanking output |

## Verification
The single instance is driven through all sixteen codes twice. The first pass, with the ripple input low, checks the glyph table against the illegal-code blanking. The second pass, with the ripple input high, shows that only code zero reacts to it. Hold sequences change the input while hold is high, which separates a transparent register from one that keeps its value. Override patterns pair lamp test and blanking with zero and nonzero stored codes under both ripple levels. This shows both the segment priority and that the ripple output ignores the overrides. A four-digit chain is swept through all 10,000 digit combinations in both chaining directions and compared against a suppression model.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int SEG_N  = 7;
  localparam int CODE_W = 4;
  typedef logic [SEG_N-1:0] seg_t;
  localparam seg_t SEG_OFF = '0;
  localparam seg_t SEG_ALL = '1;

  // bit 6 = a ... bit 0 = g
  function automatic seg_t glyph(input logic [CODE_W-1:0] code);
    case (code)
      4'd0: glyph = 7'h7E;
      4'd1: glyph = 7'h30;
      4'd2: glyph = 7'h6D;
      4'd3: glyph = 7'h79;
      4'd4: glyph = 7'h33;
      4'd5: glyph = 7'h5B;
      4'd6: glyph = 7'h5F;
      4'd7: glyph = 7'h70;
      4'd8: glyph = 7'h7F;
      4'd9: glyph = 7'h7B;
      default: glyph = SEG_OFF;
    endcase
  endfunction
endpackage

// File: rtl/bcd_hold_reg.sv
module bcd_hold_reg #(
  parameter int W = seg7_pkg::CODE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         hold_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (!hold_i) q_o <= d_i;
  end
endmodule

// File: rtl/bcd_glyph_dec.sv
module bcd_glyph_dec
  import seg7_pkg::*;
#(
  parameter int W = CODE_W,
  parameter int MAX_DIGIT = 9
) (
  input  logic [W-1:0] code_i,
  input  logic         rip_in_i,
  output seg_t         seg_o,
  output logic         zero_o
);
  localparam logic [W-1:0] MAX_CODE = W'(MAX_DIGIT);

  always_comb begin
    zero_o = (code_i == '0);
    if (code_i > MAX_CODE)       seg_o = SEG_OFF;
    else if (zero_o && rip_in_i) seg_o = SEG_OFF;
    else                         seg_o = glyph(code_i);
  end
endmodule

// File: rtl/seg_force.sv
module seg_force #(
  parameter int N = seg7_pkg::SEG_N
) (
  input  logic [N-1:0] seg_i,
  input  logic         lamp_test_ni,
  input  logic         blank_ni,
  output logic [N-1:0] seg_o
);
  // lamp test beats blanking on every segment
  for (genvar i = 0; i < N; i++) begin : g_seg
    assign seg_o[i] = !lamp_test_ni | (blank_ni & seg_i[i]);
  end
endmodule

// File: rtl/bcd_seg_latch_dec.sv
module bcd_seg_latch_dec
  import seg7_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] bcd_i,
  input  logic              hold_i,
  input  logic              lamp_test_ni,
  input  logic              blank_ni,
  input  logic              rip_in_i,
  output logic [SEG_N-1:0]  seg_o,
  output logic              rip_out_o
);
  logic [CODE_W-1:0] code_q;
  seg_t              seg_dec;
  logic              code_zero;

  bcd_hold_reg #(.W(CODE_W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bcd_i),
    .hold_i(hold_i),
    .q_o   (code_q)
  );

  bcd_glyph_dec #(.W(CODE_W)) u_dec (
    .code_i  (code_q),
    .rip_in_i(rip_in_i),
    .seg_o   (seg_dec),
    .zero_o  (code_zero)
  );

  seg_force #(.N(SEG_N)) u_force (
    .seg_i       (seg_dec),
    .lamp_test_ni(lamp_test_ni),
    .blank_ni    (blank_ni),
    .seg_o       (seg_o)
  );

  // ripple output ignores the overrides
  assign rip_out_o = rip_in_i & code_zero;
endmodule

// File: rtl/seg7_chk.sv
module seg7_chk
  import seg7_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] bcd_i,
  input logic              hold_i,
  input logic              lamp_test_ni,
  input logic              blank_ni,
  input logic              rip_in_i,
  input logic [SEG_N-1:0]  seg_o,
  input logic              rip_out_o,
  input logic [CODE_W-1:0] code_q
);
  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> code_q == $past(bcd_i));

  p_hold_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(code_q));

  p_lamp_all_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lamp_test_ni |-> seg_o == SEG_ALL);

  p_blank_all_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && !blank_ni) |-> seg_o == SEG_OFF);

  p_illegal_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && blank_ni && code_q > 4'd9) |-> seg_o == SEG_OFF);

  p_zero_ripple_dark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && blank_ni && rip_in_i && code_q == '0) |-> seg_o == SEG_OFF);

  p_ripple_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rip_out_o == (rip_in_i && code_q == '0));
endmodule

bind bcd_seg_latch_dec seg7_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bcd_i       (bcd_i),
  .hold_i      (hold_i),
  .lamp_test_ni(lamp_test_ni),
  .blank_ni    (blank_ni),
  .rip_in_i    (rip_in_i),
  .seg_o       (seg_o),
  .rip_out_o   (rip_out_o),
  .code_q      (code_q)
);

// File: tb/sim_bcd_seg_latch_dec.sv
module sim_bcd_seg_latch_dec;
  localparam int CLK_PERIOD = 10;
  localparam int DIGITS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bcd = '0;
  logic       hold = 1'b1;
  logic       lt_n = 1'b1;
  logic       bl_n = 1'b1;
  logic       rip_in = 1'b0;
  logic [6:0] seg;
  logic       rip_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_seg_latch_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .bcd_i(bcd), .hold_i(hold),
    .lamp_test_ni(lt_n), .blank_ni(bl_n), .rip_in_i(rip_in),
    .seg_o(seg), .rip_out_o(rip_out)
  );

  // four-digit chain, index 3 = most significant
  logic [3:0] ch_code [DIGITS];
  logic       ch_trail = 1'b0;
  logic [DIGITS-1:0] ch_rin, ch_rout;
  logic [6:0] ch_seg [DIGITS];

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    if (k == DIGITS-1) begin : g_top
      assign ch_rin[k] = ch_trail ? 1'b0 : 1'b1;
    end else if (k == 0) begin : g_bot
      assign ch_rin[k] = ch_trail ? 1'b1 : 1'b0;
    end else begin : g_mid
      assign ch_rin[k] = ch_trail ? ch_rout[k-1] : ch_rout[k+1];
    end
    bcd_seg_latch_dec u_dig (
      .clk_i(clk), .rst_ni(rst_n), .bcd_i(ch_code[k]), .hold_i(1'b0),
      .lamp_test_ni(1'b1), .blank_ni(1'b1), .rip_in_i(ch_rin[k]),
      .seg_o(ch_seg[k]), .rip_out_o(ch_rout[k])
    );
  end

  function automatic logic [6:0] shape(input logic [3:0] c);
    case (c)
      4'd0: return 7'h7E; 4'd1: return 7'h30; 4'd2: return 7'h6D;
      4'd3: return 7'h79; 4'd4: return 7'h33; 4'd5: return 7'h5B;
      4'd6: return 7'h5F; 4'd7: return 7'h70; 4'd8: return 7'h7F;
      4'd9: return 7'h7B; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] model_seg(input logic lt, input logic bl,
                                           input logic ri, input logic [3:0] c);
    if (!lt) return 7'h7F;
    if (!bl) return 7'h00;
    if (c == 4'd0 && ri) return 7'h00;
    return shape(c);
  endfunction

  typedef struct {
    logic [6:0] seg;
    logic       ro;
    string      tag;
  } item_t;
  item_t sb_q[$];
  logic [3:0] m_code = '0;

  task automatic drive(input logic lt, input logic bl, input logic hd,
                       input logic ri, input logic [3:0] c, input string tag);
    item_t it;
    @(negedge clk);
    lt_n = lt; bl_n = bl; hold = hd; rip_in = ri; bcd = c;
    @(posedge clk);
    if (!hd) m_code = c;
    #1;
    it.seg = model_seg(lt, bl, ri, m_code);
    it.ro  = ri && (m_code == 4'd0);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #3;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (seg !== it.seg || rip_out !== it.ro) begin
          n_errors++;
          $display("FAIL %s: seg=%h ro=%b expected seg=%h ro=%b",
                   it.tag, seg, rip_out, it.seg, it.ro);
        end
      end
    end
  end

  task automatic chain_check(input logic trail);
    logic [6:0] exp_s [DIGITS];
    bit sup;
    bit bad;
    for (int v = 0; v < 10000; v++) begin
      int t;
      t = v;
      @(negedge clk);
      ch_trail = trail;
      for (int k = 0; k < DIGITS; k++) begin
        ch_code[k] = 4'(t % 10);
        t = t / 10;
      end
      sup = 1;
      for (int k = 0; k < DIGITS; k++) exp_s[k] = shape(ch_code[k]);
      if (!trail) begin
        for (int k = DIGITS-1; k >= 1; k--) begin
          if (sup && ch_code[k] == 0) exp_s[k] = 7'h00; else sup = 0;
        end
      end else begin
        for (int k = 0; k <= DIGITS-2; k++) begin
          if (sup && ch_code[k] == 0) exp_s[k] = 7'h00; else sup = 0;
        end
      end
      @(posedge clk);
      #3;
      n_checks++;
      bad = 0;
      for (int k = 0; k < DIGITS; k++) if (ch_seg[k] !== exp_s[k]) bad = 1;
      if (bad) begin
        n_errors++;
        $display("FAIL R10 trail=%0b value=%0d: seg=%h %h %h %h expected %h %h %h %h",
                 trail, v, ch_seg[3], ch_seg[2], ch_seg[1], ch_seg[0],
                 exp_s[3], exp_s[2], exp_s[1], exp_s[0]);
      end
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : driver
    for (int k = 0; k < DIGITS; k++) ch_code[k] = '0;
    repeat (3) @(posedge clk);
    // R3: reset state, code 0 shown as zero with ripple low
    #3;
    n_checks++;
    if (seg !== 7'h7E || rip_out !== 1'b0) begin
      n_errors++;
      $display("FAIL R3 in reset: seg=%h ro=%b expected seg=7e ro=0", seg, rip_out);
    end
    @(negedge clk);
    rst_n = 1'b1;
    drive(1, 1, 1, 0, 4'd5, "R3 held after reset");
    drive(1, 1, 1, 1, 4'd5, "R9 R8 reset zero rippled");

    // R1 R7 R6: all codes, ripple low
    for (int c = 0; c < 16; c++) drive(1, 1, 0, 0, 4'(c), c < 10 ? "R1 R7 glyph" : "R6 illegal");
    // R8: ripple high, only zero reacts
    for (int c = 0; c < 16; c++) drive(1, 1, 0, 1, 4'(c), "R8 R9 ripple high");

    // R2: hold keeps code while input moves
    drive(1, 1, 0, 0, 4'd7, "R1 load 7");
    drive(1, 1, 1, 0, 4'd2, "R2 hold 7 vs 2");
    drive(1, 1, 1, 0, 4'd0, "R2 hold 7 vs 0");
    drive(1, 1, 1, 1, 4'd0, "R2 R9 hold 7 ripple");
    drive(1, 1, 0, 1, 4'd0, "R1 load 0");
    drive(1, 1, 1, 1, 4'd3, "R2 hold 0 vs 3");

    // R4 R5 R9: overrides, ripple out unaffected
    drive(0, 1, 1, 1, 4'd3, "R4 R9 lamp on zero");
    drive(0, 0, 1, 1, 4'd3, "R4 R9 lamp beats blank");
    drive(1, 0, 1, 1, 4'd3, "R5 R9 blank zero");
    drive(1, 0, 1, 0, 4'd3, "R5 R9 blank ripple low");
    drive(1, 1, 0, 0, 4'd8, "R1 load 8");
    drive(0, 0, 0, 1, 4'd12, "R4 lamp on illegal");
    drive(1, 0, 1, 0, 4'd12, "R5 blank illegal");
    drive(1, 1, 0, 1, 4'd9, "R7 nine");
    drive(1, 0, 1, 1, 4'd9, "R5 blank nine");
    drive(0, 1, 1, 1, 4'd9, "R4 lamp nine");
    @(posedge clk);
    #5;

    // R10: chained suppression both ways
    chain_check(1'b0);
    chain_check(1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule